// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block lets a small 8-bit host drive a parallel NOR flash that is guarded by software write protection. The host writes the target address and an optional program byte through one narrow register port. It then names an operation on a 2-bit code and strobes `start`. From that point the block works the flash pins on its own. A read is a timed output-enable access. Program, sector erase and chip erase are each preceded by the protection-unlock write cycles. The block produces those cycles from a small internal step table, so the host never supplies a command constant.

Each flash write cycle uses the same fixed shape. Address and data are set up one clock ahead of the write strobe, the strobe is held low for a parameterised number of clocks, and address and data stay one more clock after it is released. After the last command cycle the block waits for an operation-specific time while `busy` stays high. It then raises `done` for one clock. A read latches the flash byte into `rd_data`, and `rd_data` keeps that value until the next read.

Top module: `flash_cmd_seq`

## Requirements
- R1: A host write (`host_wr`=1) stores `host_din` into the register picked by `host_sel`: 0 is the address high byte, 1 is the address low byte, 2 is the program data byte, and 3 changes nothing.
- R2: `op_code` selects the operation: 0 read, 1 byte program, 2 sector erase, 3 chip erase. A `start` seen while idle begins the operation, and `busy` is high from the next clock.
- R3: A read holds `fl_ce_n` and `fl_oe_n` low with `fl_addr` equal to the target for exactly READ_WAIT clocks, with `fl_we_n` high. It then loads the flash byte into `rd_data`, which keeps that byte through later non-read operations.
- R4: A program issues exactly four write cycles, as (address,data): (5555h,AAh), (2AAAh,55h), (5555h,A0h), (target,data byte).
- R5: A sector erase issues six write cycles: (5555h,AAh), (2AAAh,55h), (5555h,80h), (5555h,AAh), (2AAAh,55h), then (target with its low 12 bits cleared, 30h).
- R6: A chip erase issues the same first five cycles as R5 and ends with (5555h,10h).
- R7: In every write cycle `fl_we_n` is low for exactly WE_PULSE clocks, with `fl_ce_n` low and `fl_oe_n` high. `fl_addr` and `fl_dout` hold their values from one clock before the strobe falls through one clock after it rises.
- R8: `busy` stays high for N*(WE_PULSE+2)+W clocks, where N is the number of write cycles and W is PROG_WAIT, SECTOR_WAIT or CHIP_WAIT for the operation. For a read it stays high for READ_WAIT clocks.
- R9: `done` is high for exactly one clock per operation, in the first clock where `busy` is low again.
- R10: A `start` while busy is ignored. Host register writes while busy do not change the cycles of the operation in progress.
- R11: After reset `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, and `busy`, `done`, `fl_dout_en` and `rd_data` are 0.
- R12: `fl_dout_en` is high only inside write cycles and never while `fl_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select |
| host_din | input | 8 | Host write data |
| op_code | input | 2 | Requested operation |
| start | input | 1 | Operation request strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Last byte read from flash |
| fl_addr | output | 16 | Flash address |
| fl_dout | output | 8 | Data driven to flash |
| fl_dout_en | output | 1 | Enable for the flash data drivers |
| fl_din | input | 8 | Data returned by flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
A wrong step index or a bad table entry shows up at the very next rising edge of `fl_we_n` as an unexpected address/data pair in the write log. A timer loaded with the wrong value stretches or shortens a strobe in that same cycle. Busy counts that are off by one also reveal a wrong wait value. A state that fails to return to idle appears as a missing `done` pulse, which the bench catches within one operation's time. A snapshot that is not taken at `start` lets a host write made in the middle of an operation leak into the final program or erase cycle.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int STEP_W = 3;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SEL_AHI  = 2'd0,
        SEL_ALO  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_WAIT
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_cyc_t;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } job_t;

    // unlock constants
    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [DATA_W-1:0] KEY_DATA_A = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_DATA_B = 8'h55;
    localparam logic [DATA_W-1:0] CMD_PROG   = 8'hA0;
    localparam logic [DATA_W-1:0] CMD_ERASE  = 8'h80;
    localparam logic [DATA_W-1:0] CMD_SECT   = 8'h30;
    localparam logic [DATA_W-1:0] CMD_CHIP   = 8'h10;

    function automatic logic [STEP_W-1:0] final_step(op_e op);
        return (op == OP_PROG) ? STEP_W'(3) : STEP_W'(5);
    endfunction

endpackage

// File: rtl/flseq_hostregs.sv
module flseq_hostregs
    import flseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [1:0]           sel,
    input  logic [DATA_W-1:0]    din,
    output logic [ADDR_W-1:0]    addr,
    output logic [DATA_W-1:0]    data
);
    logic [DATA_W-1:0] hi_q, lo_q, dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            lo_q  <= '0;
            dat_q <= '0;
        end else if (wr) begin
            case (sel_e'(sel))
                SEL_AHI:  hi_q  <= din;
                SEL_ALO:  lo_q  <= din;
                SEL_DATA: dat_q <= din;
                default:  ;
            endcase
        end
    end

    assign addr = {hi_q, lo_q};
    assign data = dat_q;
endmodule

// File: rtl/flseq_cmdgen.sv
module flseq_cmdgen
    import flseq_pkg::*;
#(
    parameter int SECT_LOG2 = 12
) (
    input  job_t              job,
    input  logic [STEP_W-1:0] step,
    output bus_cyc_t          cyc,
    output logic              last
);
    localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECT_LOG2) - ADDR_W'(1));

    logic [ADDR_W-1:0] sect_base;
    assign sect_base = job.addr & SECT_MASK;

    always_comb begin
        cyc = '{addr: KEY_ADDR_A, data: KEY_DATA_A};
        case (step)
            3'd0: cyc = '{addr: KEY_ADDR_A, data: KEY_DATA_A};
            3'd1: cyc = '{addr: KEY_ADDR_B, data: KEY_DATA_B};
            3'd2: cyc = '{addr: KEY_ADDR_A,
                          data: (job.op == OP_PROG) ? CMD_PROG : CMD_ERASE};
            3'd3: cyc = (job.op == OP_PROG) ? '{addr: job.addr, data: job.data}
                                            : '{addr: KEY_ADDR_A, data: KEY_DATA_A};
            3'd4: cyc = '{addr: KEY_ADDR_B, data: KEY_DATA_B};
            3'd5: cyc = (job.op == OP_SECT) ? '{addr: sect_base, data: CMD_SECT}
                                            : '{addr: KEY_ADDR_A, data: CMD_CHIP};
            default: cyc = '{addr: KEY_ADDR_A, data: KEY_DATA_A};
        endcase
    end

    assign last = (step == final_step(job.op));
endmodule

// File: rtl/flseq_timer.sv
module flseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flseq_pkg::*;
#(
    parameter int WE_PULSE    = 3,
    parameter int READ_WAIT   = 4,
    parameter int PROG_WAIT   = 20,
    parameter int SECTOR_WAIT = 200,
    parameter int CHIP_WAIT   = 800,
    parameter int SECT_LOG2   = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [1:0]  host_sel,
    input  logic [7:0]  host_din,
    input  logic [1:0]  op_code,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rd_data,
    output logic [15:0] fl_addr,
    output logic [7:0]  fl_dout,
    output logic        fl_dout_en,
    input  logic [7:0]  fl_din,
    output logic        fl_ce_n,
    output logic        fl_oe_n,
    output logic        fl_we_n
);
    localparam int MAX_A = (WE_PULSE > READ_WAIT) ? WE_PULSE : READ_WAIT;
    localparam int MAX_B = (PROG_WAIT > SECTOR_WAIT) ? PROG_WAIT : SECTOR_WAIT;
    localparam int MAX_C = (CHIP_WAIT > MAX_B) ? CHIP_WAIT : MAX_B;
    localparam int MAX_W = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W = $clog2(MAX_W + 1);

    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] reg_data;
    state_e            state_q;
    job_t              job_q;
    logic [STEP_W-1:0] step_q;
    bus_cyc_t          cyc;
    logic              cyc_last;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              done_q;
    logic [7:0]        rd_q;
    logic              in_write;

    flseq_hostregs u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr   (host_wr),
        .sel  (host_sel),
        .din  (host_din),
        .addr (reg_addr),
        .data (reg_data)
    );

    flseq_cmdgen #(.SECT_LOG2(SECT_LOG2)) u_gen (
        .job  (job_q),
        .step (step_q),
        .cyc  (cyc),
        .last (cyc_last)
    );

    flseq_timer #(.W(CNT_W)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    function automatic logic [CNT_W-1:0] settle_len(op_e op);
        case (op)
            OP_PROG: return CNT_W'(PROG_WAIT - 1);
            OP_SECT: return CNT_W'(SECTOR_WAIT - 1);
            default: return CNT_W'(CHIP_WAIT - 1);
        endcase
    endfunction

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: if (start && op_e'(op_code) == OP_READ) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(READ_WAIT - 1);
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WE_PULSE - 1);
            end
            ST_HOLD: if (cyc_last) begin
                tmr_load = 1'b1;
                tmr_val  = settle_len(job_q.op);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            job_q   <= '{op: OP_READ, addr: '0, data: '0};
            step_q  <= '0;
            done_q  <= 1'b0;
            rd_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    job_q   <= '{op: op_e'(op_code), addr: reg_addr, data: reg_data};
                    step_q  <= '0;
                    state_q <= (op_e'(op_code) == OP_READ) ? ST_RD : ST_SETUP;
                end
                ST_RD: if (tmr_zero) begin
                    rd_q    <= fl_din;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_SETUP: state_q <= ST_PULSE;
                ST_PULSE: if (tmr_zero) state_q <= ST_HOLD;
                ST_HOLD: begin
                    if (cyc_last) begin
                        state_q <= ST_WAIT;
                    end else begin
                        step_q  <= step_q + STEP_W'(1);
                        state_q <= ST_SETUP;
                    end
                end
                ST_WAIT: if (tmr_zero) begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_write   = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign rd_data    = rd_q;
    assign fl_ce_n    = !(in_write || state_q == ST_RD);
    assign fl_oe_n    = (state_q != ST_RD);
    assign fl_we_n    = (state_q != ST_PULSE);
    assign fl_dout_en = in_write;
    assign fl_dout    = in_write ? cyc.data : '0;
    assign fl_addr    = (state_q == ST_RD) ? job_q.addr : (in_write ? cyc.addr : '0);
endmodule

module flseq_checks (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [15:0] fl_addr,
    input logic [7:0]  fl_dout,
    input logic        fl_dout_en,
    input logic        fl_ce_n,
    input logic        fl_oe_n,
    input logic        fl_we_n
);
    a_r7_strobe_framing: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n));

    a_r7_setup_held: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dout)));

    a_r7_pulse_held: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

    a_r7_hold_held: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dout)));

    a_r3_read_exclusive: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (fl_we_n && !fl_ce_n && busy));

    a_r12_drive_in_write: assert property (@(posedge clk) disable iff (rst)
        fl_dout_en |-> (!fl_ce_n && fl_oe_n));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r2_start_begins: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
endmodule

bind flash_cmd_seq flseq_checks u_checks (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .fl_addr    (fl_addr),
    .fl_dout    (fl_dout),
    .fl_dout_en (fl_dout_en),
    .fl_ce_n    (fl_ce_n),
    .fl_oe_n    (fl_oe_n),
    .fl_we_n    (fl_we_n)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
    localparam int WE_P = 3;
    localparam int RD_W = 4;
    localparam int PG_W = 10;
    localparam int SE_W = 25;
    localparam int CE_W = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [7:0]  host_din = 8'd0;
    logic [1:0]  op_code = 2'd0;
    logic        start = 1'b0;
    logic        busy, done, fl_dout_en, fl_ce_n, fl_oe_n, fl_we_n;
    logic [7:0]  rd_data, fl_dout, fl_din;
    logic [15:0] fl_addr;

    logic [15:0] pre_addr = 16'h0000;
    logic [7:0]  pre_val  = 8'h00;

    assign fl_din = (!fl_ce_n && !fl_oe_n) ? ((fl_addr == pre_addr) ? pre_val : 8'hEE) : 8'h00;

    always #5 clk = ~clk;

    flash_cmd_seq #(
        .WE_PULSE(WE_P), .READ_WAIT(RD_W), .PROG_WAIT(PG_W),
        .SECTOR_WAIT(SE_W), .CHIP_WAIT(CE_W), .SECT_LOG2(12)
    ) uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
        .host_din(host_din), .op_code(op_code), .start(start),
        .busy(busy), .done(done), .rd_data(rd_data), .fl_addr(fl_addr),
        .fl_dout(fl_dout), .fl_dout_en(fl_dout_en), .fl_din(fl_din),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // monitor state
    int busy_cnt, done_cnt, done_bad, we_run, pulse_bad, setup_bad, hold_bad, ctl_bad;
    int oe_cnt, drive_bad;
    logic [15:0] oe_addr;
    logic [15:0] log_a[$];
    logic [7:0]  log_d[$];
    logic [15:0] prev_addr = 16'h0;
    logic [7:0]  prev_dout = 8'h0;
    logic        prev_we = 1'b1;
    logic [15:0] exp_a[$];
    logic [7:0]  exp_d[$];

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        busy_cnt = 0; done_cnt = 0; done_bad = 0; we_run = 0;
        pulse_bad = 0; setup_bad = 0; hold_bad = 0; ctl_bad = 0;
        oe_cnt = 0; drive_bad = 0; oe_addr = 16'h0;
        log_a.delete(); log_d.delete();
        exp_a.delete(); exp_d.delete();
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (done) begin
                done_cnt++;
                if (busy) done_bad++;
            end
            if (fl_dout_en && !fl_oe_n) drive_bad++;
            if (!fl_we_n) begin
                we_run++;
                if (fl_ce_n || !fl_oe_n || !fl_dout_en) ctl_bad++;
                if (fl_addr != prev_addr || fl_dout != prev_dout) setup_bad++;
            end
            if (fl_we_n && !prev_we) begin
                log_a.push_back(fl_addr);
                log_d.push_back(fl_dout);
                if (we_run != WE_P) pulse_bad++;
                we_run = 0;
                if (fl_addr != prev_addr || fl_dout != prev_dout) hold_bad++;
            end
            if (!fl_oe_n) begin
                oe_cnt++;
                oe_addr = fl_addr;
            end
        end
        prev_we   = fl_we_n;
        prev_addr = fl_addr;
        prev_dout = fl_dout;
    end

    task automatic host_write(logic [1:0] sel, logic [7:0] val);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_din = val;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic launch(logic [1:0] op);
        @(posedge clk);
        clear_mon();
        @(negedge clk);
        op_code = op; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int guard = 0;
        while (done_cnt == 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(done_cnt != 0, tag, 0, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic push_unlock();
        exp_a.push_back(16'h5555); exp_d.push_back(8'hAA);
        exp_a.push_back(16'h2AAA); exp_d.push_back(8'h55);
    endtask

    task automatic compare_log(string tag);
        check(log_a.size() == exp_a.size(), {tag, " cycle count"}, log_a.size(), exp_a.size());
        foreach (exp_a[i]) begin
            if (i < log_a.size()) begin
                check(log_a[i] == exp_a[i], {tag, " cycle addr"}, log_a[i], exp_a[i]);
                check(log_d[i] == exp_d[i], {tag, " cycle data"}, log_d[i], exp_d[i]);
            end
        end
    endtask

    task automatic check_timing(string tag, int exp_busy);
        check(pulse_bad == 0, "R7 strobe width", pulse_bad, 0);
        check(setup_bad == 0 && hold_bad == 0, "R7 addr/data stable", setup_bad + hold_bad, 0);
        check(ctl_bad == 0, "R7 strobe controls", ctl_bad, 0);
        check(drive_bad == 0, "R12 drive vs oe", drive_bad, 0);
        check(busy_cnt == exp_busy, {"R8 busy length ", tag}, busy_cnt, exp_busy);
        check(done_cnt == 1 && done_bad == 0, {"R9 done pulse ", tag}, done_cnt, 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(fl_ce_n && fl_oe_n && fl_we_n, "R11 strobes idle", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
        check(!busy && !done, "R11 busy/done low", {busy, done}, 0);
        check(rd_data == 8'h00, "R11 rd_data", rd_data, 0);
        check(!fl_dout_en, "R11 R12 drive off", fl_dout_en, 0);
    endtask

    task automatic test_read();
        host_write(2'd0, 8'h4C);
        host_write(2'd1, 8'h21);
        pre_addr = 16'h4C21; pre_val = 8'h9B;
        launch(2'd0);
        check(busy, "R2 busy after start", busy, 1);
        wait_done("R3 read done");
        check(rd_data == 8'h9B, "R3 read byte", rd_data, 8'h9B);
        check(oe_cnt == RD_W, "R3 oe length", oe_cnt, RD_W);
        check(oe_addr == 16'h4C21, "R3 read addr", oe_addr, 16'h4C21);
        check(log_a.size() == 0, "R3 no write cycles", log_a.size(), 0);
        check(busy_cnt == RD_W && done_cnt == 1, "R8 R9 read busy", busy_cnt, RD_W);
    endtask

    task automatic test_program();
        host_write(2'd0, 8'h12);
        host_write(2'd1, 8'h34);
        host_write(2'd2, 8'h5A);
        launch(2'd1);
        wait_done("R4 program done");
        push_unlock();
        exp_a.push_back(16'h5555); exp_d.push_back(8'hA0);
        exp_a.push_back(16'h1234); exp_d.push_back(8'h5A);
        compare_log("R4 program");
        check_timing("program", 4 * (WE_P + 2) + PG_W);
        check(rd_data == 8'h9B, "R3 rd_data kept", rd_data, 8'h9B);
    endtask

    task automatic test_sector();
        host_write(2'd0, 8'h3A);
        host_write(2'd1, 8'hBC);
        launch(2'd2);
        wait_done("R5 sector done");
        push_unlock();
        exp_a.push_back(16'h5555); exp_d.push_back(8'h80);
        push_unlock();
        exp_a.push_back(16'h3000); exp_d.push_back(8'h30);
        compare_log("R5 sector erase");
        check_timing("sector", 6 * (WE_P + 2) + SE_W);
    endtask

    task automatic test_chip();
        launch(2'd3);
        wait_done("R6 chip done");
        push_unlock();
        exp_a.push_back(16'h5555); exp_d.push_back(8'h80);
        push_unlock();
        exp_a.push_back(16'h5555); exp_d.push_back(8'h10);
        compare_log("R6 chip erase");
        check_timing("chip", 6 * (WE_P + 2) + CE_W);
    endtask

    task automatic test_busy_ignore();
        host_write(2'd0, 8'h77);
        host_write(2'd1, 8'h01);
        host_write(2'd2, 8'hC3);
        launch(2'd1);
        repeat (3) @(negedge clk);
        host_wr = 1'b1; host_sel = 2'd0; host_din = 8'hFF;
        @(negedge clk);
        host_sel = 2'd2; host_din = 8'h00;
        @(negedge clk);
        host_wr = 1'b0;
        op_code = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10 program done");
        push_unlock();
        exp_a.push_back(16'h5555); exp_d.push_back(8'hA0);
        exp_a.push_back(16'h7701); exp_d.push_back(8'hC3);
        compare_log("R10 busy ignore");
        check(busy_cnt == 4 * (WE_P + 2) + PG_W && done_cnt == 1,
              "R10 second start ignored", busy_cnt, 4 * (WE_P + 2) + PG_W);
    endtask

    task automatic test_sel_none();
        host_write(2'd0, 8'h12);
        host_write(2'd1, 8'h34);
        host_write(2'd2, 8'h66);
        host_write(2'd3, 8'hFF);
        pre_addr = 16'h1234; pre_val = 8'h3D;
        launch(2'd0);
        wait_done("R1 read done");
        check(oe_addr == 16'h1234, "R1 address regs", oe_addr, 16'h1234);
        check(rd_data == 8'h3D, "R1 read via regs", rd_data, 8'h3D);
        launch(2'd1);
        wait_done("R1 program done");
        check(log_d.size() == 4 && log_d[3] == 8'h66, "R1 data reg unchanged by sel 3",
              (log_d.size() == 4) ? log_d[3] : 8'h00, 8'h66);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_read();
        test_program();
        test_sector();
        test_chip();
        test_busy_ignore();
        test_sel_none();
        summary();
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual 0 expected 1");
        summary();
    end
endmodule